// File: doc/BRIEF.md
# Branch, Skip and Index-Modify Next-Address Sequencer

This block decides where a word-addressed CPU goes after a control-transfer instruction. Each cycle the decode stage may present one instruction together with its word address, its form (one word or two), a target address, a six-bit condition-select mask, the live condition flags, and an index-register operand. One clock later the block returns the next instruction address. Depending on the operation it also returns a memory write that carries a return address, or a write-back value for an index register.

Four operations are handled, plus a plain sequential step:
- A subroutine call stores the address after the call into the target word and resumes one word past the target.
- The one-word conditional skips over the following instruction when any selected flag is set.
- The two-word conditional branches to the target only when no selected flag is set.
- Modify-index adds a signed amount to an index register, and skips when the result is zero or has changed sign. When the instruction address is the destination, it adds to the instruction address and acts as a relative jump.

Memory, the arithmetic datapath and instruction fetch live elsewhere.

Top module: `ctl_xfer_seq`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: An edge with `ins_vld` low gives `nxt_vld`, `mem_we` and `idx_we` all low after that edge.
- R3: Every result appears exactly one clock edge after its instruction is presented. The sequential length `len` is 1 when `ins_long` is 0 and 2 when it is 1, and all address arithmetic wraps modulo 2^W.
- R4: Call (`ins_op`=1) raises `mem_we` for that result, with `mem_addr`=target, `mem_data`=IAR+len and `nxt_iar`=target+1.
- R5: One-word conditional (`ins_op`=2, `ins_long`=0) gives `nxt_iar`=IAR+2 when any bit of `cond_mask & cond_flags` is set, and IAR+1 otherwise. The flag bits are [0] zero, [1] negative, [2] positive, [3] even, [4] carry, [5] overflow.
- R6: Two-word conditional (`ins_op`=2, `ins_long`=1) gives `nxt_iar`=target when no bit of `cond_mask & cond_flags` is set, and IAR+2 otherwise.
- R7: An all-zero `cond_mask` never skips in the one-word form and always branches in the two-word form.
- R8: Modify-index with `mod_sel` 1..3 raises `idx_we`, echoes `mod_sel` on `idx_sel`, and gives `idx_val`=`idx_cur`+`mod_delta`.
- R9: Modify-index with `mod_sel` 1..3 gives `nxt_iar`=IAR+len+1 when the new index value is zero or its top bit differs from the top bit of `idx_cur`, and IAR+len otherwise.
- R10: Modify-index with `mod_sel`=0 gives `nxt_iar`=IAR+len+`mod_delta`, with no index write and no skip.
- R11: Sequential (`ins_op`=0) gives `nxt_iar`=IAR+len with neither write strobe raised. At most one of `mem_we` and `idx_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | 1 | An instruction is presented this cycle |
| ins_op | input | 2 | 0 sequential, 1 call, 2 conditional, 3 modify-index |
| ins_long | input | 1 | Two-word instruction form |
| ins_iar | input | W | Address of the presented instruction |
| ins_target | input | W | Effective target address |
| cond_mask | input | 6 | Condition select mask |
| cond_flags | input | 6 | Live condition flags |
| mod_sel | input | 2 | Modify destination: 0 instruction address, 1..3 index register |
| mod_delta | input | W | Signed amount added by modify-index |
| idx_cur | input | W | Current value of the selected index register |
| nxt_vld | output | 1 | Result valid |
| nxt_iar | output | W | Next instruction address |
| mem_we | output | 1 | Return-address write strobe |
| mem_addr | output | W | Return-address write location |
| mem_data | output | W | Return address |
| idx_we | output | 1 | Index write-back strobe |
| idx_sel | output | 2 | Index register being written |
| idx_val | output | W | New index value |

## Verification
The bench builds the block with W=8, so address and index arithmetic wraps at 256. The full operand space then fits inside a short run. Every index value is paired with every signed amount in the one-word modify form, which reaches every zero result, sign crossing and wrap. Every mask and flag pair is swept in both conditional forms, which covers the empty mask and each single flag position. Instruction-address modify and call cases run across wrapping addresses in both forms.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int NFLAG = 6;

    typedef enum logic [1:0] {
        XOP_SEQ  = 2'd0,
        XOP_CALL = 2'd1,
        XOP_COND = 2'd2,
        XOP_MOD  = 2'd3
    } xop_e;

    // any selected flag set
    function automatic logic cond_hit(input logic [NFLAG-1:0] m, input logic [NFLAG-1:0] f);
        return |(m & f);
    endfunction

endpackage

// File: rtl/xfer_cond.sv
module xfer_cond import xfer_pkg::*; #(
    parameter int W = 16
) (
    input  logic             long_form,
    input  logic [W-1:0]     iar,
    input  logic [W-1:0]     target,
    input  logic [NFLAG-1:0] mask,
    input  logic [NFLAG-1:0] flags,
    output logic [W-1:0]     nxt
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    logic [NFLAG-1:0] hits;

    genvar g;
    generate
        for (g = 0; g < NFLAG; g++) begin : g_hit
            assign hits[g] = cond_hit(mask[g], flags[g]);
        end
    endgenerate

    logic any_hit;
    assign any_hit = |hits;

    // Short form skips on a hit; long form branches on no hit.
    always_comb begin
        if (long_form)
            nxt = any_hit ? (iar + TWO) : target;
        else
            nxt = any_hit ? (iar + TWO) : (iar + ONE);
    end
endmodule

// File: rtl/xfer_modify.sv
module xfer_modify #(
    parameter int W = 16
) (
    input  logic [W-1:0] orig,
    input  logic [W-1:0] delta,
    output logic [W-1:0] res,
    output logic         skip
);
    assign res  = orig + delta;
    assign skip = (res == '0) || (res[W-1] != orig[W-1]);
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq import xfer_pkg::*; #(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_vld,
    input  logic [1:0]       ins_op,
    input  logic             ins_long,
    input  logic [W-1:0]     ins_iar,
    input  logic [W-1:0]     ins_target,
    input  logic [NFLAG-1:0] cond_mask,
    input  logic [NFLAG-1:0] cond_flags,
    input  logic [1:0]       mod_sel,
    input  logic [W-1:0]     mod_delta,
    input  logic [W-1:0]     idx_cur,
    output logic             nxt_vld,
    output logic [W-1:0]     nxt_iar,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_data,
    output logic             idx_we,
    output logic [1:0]       idx_sel,
    output logic [W-1:0]     idx_val
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] iar;
        logic         we;
        logic [W-1:0] waddr;
        logic [W-1:0] wdata;
        logic         iwe;
        logic [1:0]   isel;
        logic [W-1:0] ival;
    } xres_t;

    xop_e         op;
    logic [W-1:0] seq_addr;
    logic [W-1:0] cond_nxt;
    logic [W-1:0] mod_res;
    logic         mod_skip;
    xres_t        nx;
    xres_t        rq;

    assign op       = xop_e'(ins_op);
    assign seq_addr = ins_iar + (ins_long ? TWO : ONE);

    xfer_cond #(.W(W)) u_cond (
        .long_form (ins_long),
        .iar       (ins_iar),
        .target    (ins_target),
        .mask      (cond_mask),
        .flags     (cond_flags),
        .nxt       (cond_nxt)
    );

    xfer_modify #(.W(W)) u_mod (
        .orig  (idx_cur),
        .delta (mod_delta),
        .res   (mod_res),
        .skip  (mod_skip)
    );

    always_comb begin
        nx     = '0;
        nx.vld = ins_vld;
        nx.iar = seq_addr;
        unique case (op)
            XOP_SEQ: nx.iar = seq_addr;
            XOP_CALL: begin
                nx.we    = 1'b1;
                nx.waddr = ins_target;
                nx.wdata = seq_addr;
                nx.iar   = ins_target + ONE;
            end
            XOP_COND: nx.iar = cond_nxt;
            XOP_MOD: begin
                if (mod_sel == 2'd0) begin
                    nx.iar = seq_addr + mod_delta;
                end else begin
                    nx.iwe  = 1'b1;
                    nx.isel = mod_sel;
                    nx.ival = mod_res;
                    nx.iar  = mod_skip ? (seq_addr + ONE) : seq_addr;
                end
            end
            default: nx.iar = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq <= '0;
        end else if (ins_vld) begin
            rq <= nx;
        end else begin
            rq.vld <= 1'b0;
            rq.we  <= 1'b0;
            rq.iwe <= 1'b0;
        end
    end

    assign nxt_vld  = rq.vld;
    assign nxt_iar  = rq.iar;
    assign mem_we   = rq.we;
    assign mem_addr = rq.waddr;
    assign mem_data = rq.wdata;
    assign idx_we   = rq.iwe;
    assign idx_sel  = rq.isel;
    assign idx_val  = rq.ival;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         ins_vld,
    input logic [1:0]   ins_op,
    input logic         ins_long,
    input logic [W-1:0] ins_iar,
    input logic [W-1:0] ins_target,
    input logic [5:0]   cond_mask,
    input logic [1:0]   mod_sel,
    input logic [W-1:0] mod_delta,
    input logic         nxt_vld,
    input logic [W-1:0] nxt_iar,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_data,
    input logic         idx_we,
    input logic [1:0]   idx_sel
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !ins_vld |=> (!nxt_vld && !mem_we && !idx_we));

    assert_call_R4: assert property (@(posedge clk) disable iff (rst)
        (ins_vld && ins_op == 2'd1) |=>
            (mem_we && mem_addr == $past(ins_target)
             && nxt_iar == $past(ins_target) + ONE
             && mem_data == $past(ins_iar) + ($past(ins_long) ? TWO : ONE)));

    assert_empty_short_R7: assert property (@(posedge clk) disable iff (rst)
        (ins_vld && ins_op == 2'd2 && !ins_long && cond_mask == '0) |=>
            (nxt_iar == $past(ins_iar) + ONE));

    assert_empty_long_R7: assert property (@(posedge clk) disable iff (rst)
        (ins_vld && ins_op == 2'd2 && ins_long && cond_mask == '0) |=>
            (nxt_iar == $past(ins_target)));

    assert_idx_sel_R8: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> (nxt_vld && idx_sel != 2'd0));

    assert_iar_mod_R10: assert property (@(posedge clk) disable iff (rst)
        (ins_vld && ins_op == 2'd3 && mod_sel == 2'd0) |=>
            (!idx_we && !mem_we
             && nxt_iar == $past(ins_iar) + ($past(ins_long) ? TWO : ONE) + $past(mod_delta)));

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, idx_we}));
endmodule

bind ctl_xfer_seq xfer_seq_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ins_vld    (ins_vld),
    .ins_op     (ins_op),
    .ins_long   (ins_long),
    .ins_iar    (ins_iar),
    .ins_target (ins_target),
    .cond_mask  (cond_mask),
    .mod_sel    (mod_sel),
    .mod_delta  (mod_delta),
    .nxt_vld    (nxt_vld),
    .nxt_iar    (nxt_iar),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .idx_we     (idx_we),
    .idx_sel    (idx_sel)
);

// File: tb/sim_ctl_xfer_seq.sv
`timescale 1ns/1ps
module sim_ctl_xfer_seq;
    localparam int W = 8;
    localparam int M = 255;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ins_vld = 1'b0;
    logic [1:0]   ins_op = '0;
    logic         ins_long = 1'b0;
    logic [W-1:0] ins_iar = '0;
    logic [W-1:0] ins_target = '0;
    logic [5:0]   cond_mask = '0;
    logic [5:0]   cond_flags = '0;
    logic [1:0]   mod_sel = '0;
    logic [W-1:0] mod_delta = '0;
    logic [W-1:0] idx_cur = '0;
    logic         nxt_vld;
    logic [W-1:0] nxt_iar;
    logic         mem_we;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_data;
    logic         idx_we;
    logic [1:0]   idx_sel;
    logic [W-1:0] idx_val;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ctl_xfer_seq #(.W(W)) u0 (.*);

    task automatic cmp(input string rq, input string fld, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, fld, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge, check its result at the next falling edge.
    task automatic apply(input string rq, input int op, input int lng, input int iar,
                         input int tgt, input int msk, input int flg, input int sel,
                         input int dlt, input int idx);
        int len, seq, e_iar, e_we, e_iwe, e_ival, hit;
        ins_vld = 1'b1; ins_op = op[1:0]; ins_long = lng[0];
        ins_iar = iar[W-1:0]; ins_target = tgt[W-1:0];
        cond_mask = msk[5:0]; cond_flags = flg[5:0];
        mod_sel = sel[1:0]; mod_delta = dlt[W-1:0]; idx_cur = idx[W-1:0];
        len = lng ? 2 : 1;
        seq = (iar + len) & M;
        hit = ((msk & flg) != 0) ? 1 : 0;
        e_we = 0; e_iwe = 0; e_ival = 0;
        case (op)
            1: begin e_we = 1; e_iar = (tgt + 1) & M; end
            2: begin
                if (lng) e_iar = hit ? ((iar + 2) & M) : tgt;
                else     e_iar = hit ? ((iar + 2) & M) : ((iar + 1) & M);
            end
            3: begin
                if (sel == 0) e_iar = (seq + dlt) & M;
                else begin
                    e_iwe = 1;
                    e_ival = (idx + dlt) & M;
                    if (e_ival == 0 || ((e_ival >> 7) & 1) != ((idx >> 7) & 1))
                        e_iar = (seq + 1) & M;
                    else
                        e_iar = seq;
                end
            end
            default: e_iar = seq;
        endcase
        @(negedge clk);
        cmp(rq, "nxt_vld", int'(nxt_vld), 1);
        cmp(rq, "nxt_iar", int'(nxt_iar), e_iar);
        cmp(rq, "mem_we", int'(mem_we), e_we);
        cmp(rq, "idx_we", int'(idx_we), e_iwe);
        if (e_we != 0) begin
            cmp(rq, "mem_addr", int'(mem_addr), tgt);
            cmp(rq, "mem_data", int'(mem_data), seq);
        end
        if (e_iwe != 0) begin
            cmp(rq, "idx_sel", int'(idx_sel), sel);
            cmp(rq, "idx_val", int'(idx_val), e_ival);
        end
    endtask

    task automatic idle_check();
        ins_vld = 1'b0;
        ins_op = 2'd1;
        @(negedge clk);
        cmp("R2", "nxt_vld", int'(nxt_vld), 0);
        cmp("R2", "mem_we", int'(mem_we), 0);
        cmp("R2", "idx_we", int'(idx_we), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "nxt_vld", int'(nxt_vld), 0);
        cmp("R1", "nxt_iar", int'(nxt_iar), 0);
        cmp("R1", "mem_we", int'(mem_we), 0);
        cmp("R1", "idx_we", int'(idx_we), 0);
        cmp("R1", "idx_val", int'(idx_val), 0);
        rst = 1'b0;

        // R11: sequential step, both forms, wrapping addresses
        for (int a = 250; a < 262; a++) begin
            apply("R11", 0, a & 1, a & M, 0, 63, 63, 1, 5, 9);
        end
        idle_check();

        // R4: call in both forms, target near the wrap point
        for (int t = 0; t < 40; t++) begin
            apply("R4", 1, t & 1, (t * 37 + 254) & M, (t * 11 + 250) & M, 0, 0, 0, 0, 0);
        end
        // R3: back-to-back results keep one-cycle spacing
        apply("R3", 1, 0, 10, 20, 0, 0, 0, 0, 0);
        apply("R3", 0, 1, 30, 0, 0, 0, 0, 0, 0);
        idle_check();

        // R5 R6 R7: every mask and flag pair, both forms
        for (int lng = 0; lng < 2; lng++) begin
            for (int m = 0; m < 64; m++) begin
                for (int f = 0; f < 64; f++) begin
                    if (m == 0)
                        apply("R7", 2, lng, (m * 5 + f * 3 + 253) & M, (f * 7 + m) & M, m, f, 0, 0, 0);
                    else if (lng == 0)
                        apply("R5", 2, lng, (m * 5 + f * 3 + 253) & M, (f * 7 + m) & M, m, f, 0, 0, 0);
                    else
                        apply("R6", 2, lng, (m * 5 + f * 3 + 253) & M, (f * 7 + m) & M, m, f, 0, 0, 0);
                end
            end
        end
        idle_check();

        // R8 R9: every index value with every signed amount, one-word form
        for (int o = 0; o < 256; o++) begin
            for (int d = 0; d < 256; d++) begin
                apply("R9", 3, 0, (o + d) & M, 0, 0, 0, 1 + ((o + d) % 3), d, o);
            end
        end
        // R8 R9: two-word form, sampled index values
        for (int o = 0; o < 256; o += 5) begin
            for (int d = 0; d < 256; d++) begin
                apply("R8", 3, 1, (o * 3 + d) & M, 0, 0, 0, 3 - (d % 3), d, o);
            end
        end
        idle_check();

        // R10: instruction-address modify as relative jump, both forms
        for (int a = 0; a < 256; a += 3) begin
            for (int d = 0; d < 256; d++) begin
                apply("R10", 3, (a + d) & 1, a, 0, 0, 0, 0, d, (a ^ d) & M);
            end
        end
        idle_check();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog run did not complete actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule